// File: doc/BRIEF.md
# Periodic Interrupt and Event Flag Unit

This block is the interrupt side of a real-time clock. A free-running binary divider advances on a reference strobe that pulses at 65.536 kHz. A 4-bit rate code picks one tap of that divider. The chosen tap drives a periodic event and, when enabled, a square-wave pin. Code 0 turns both off. Codes 1 to 15 give frequencies that halve at each step, from 32.768 kHz down to 2 Hz.

Three event sources set sticky flags in a status byte: the periodic tap, an alarm-match pulse and an update-ended pulse. The alarm compare and the bus decode sit outside this block. The bus decode supplies a one-cycle read strobe for the status byte. The byte shows its current value during the strobe cycle, and all flags clear at the end of that cycle. Each source has its own enable. The top status bit and the active-high `irq` pin are raised while at least one pending flag has its enable set.

Top module: `pirq_unit`

## Requirements
- R1: After reset, `stat_byte` is 0x00, `irq` is low and `sqw_out` is low.
- R2: For a rate code c from 1 to 15, the periodic event occurs once every 2^c reference strobes. Code 1 is therefore 32.768 kHz and code 15 is 2 Hz.
- R3: With rate code 0, no periodic event occurs and `sqw_out` stays low.
- R4: When `sqw_en` is high and the rate code is nonzero, `sqw_out` is a square wave with a period of 2^c strobes, high for half of it. When `sqw_en` is low, `sqw_out` is low.
- R5: Status byte layout: bit 6 is the periodic flag, bit 5 the alarm flag, bit 4 the update-ended flag, and bits 3:0 read as zero.
- R6: Each of the three flags latches on its event whatever the state of its enable.
- R7: Status bit 7 is high exactly when some flag is set and its enable is high. The enables are `irq_en` bit 2 for periodic, bit 1 for alarm and bit 0 for update-ended. `irq` equals status bit 7, including when an enable is raised after its flag is already pending.
- R8: A cycle with `stat_rd` high presents the current status byte and clears every flag at the following clock edge.
- R9: An event arriving in the same cycle as `stat_rd` is not lost. It is pending after that edge and appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe at 65.536 kHz that advances the divider |
| rate_code | input | 4 | Periodic rate select; 0 means off |
| irq_en | input | 3 | Enables: bit 2 periodic, bit 1 alarm, bit 0 update-ended |
| sqw_en | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | One-cycle alarm-match pulse |
| update_evt | input | 1 | One-cycle update-ended pulse |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| stat_byte | output | 8 | Status byte: summary, three flags, four zero bits |
| irq | output | 1 | Active-high interrupt request |
| sqw_out | output | 1 | Square-wave output |

## Verification
A flag stuck high would keep `irq` and bit 7 asserted in the cycle after a read, so the next read would expose it at once. A lost flag would show up as a missing bit in the scoreboard's very next expected byte. A divider that is off by one tap would give a measured spacing of periodic flags that is wrong by a factor of two within one period, about 2^c cycles. A square-wave half period that does not match would show up within that same window.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NSRC          = 3;
  localparam int SRC_UPD       = 0;
  localparam int SRC_ALM       = 1;
  localparam int SRC_PER       = 2;
  localparam int STAT_W        = 8;
  localparam int STAT_FLAG_LSB = 4;
endpackage

// File: rtl/pirq_divider.sv
module pirq_divider #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              sqw_en,
  output logic              per_evt,
  output logic              sqw_out
);
  localparam int DIV_W = (1 << RATE_W) - 1;

  logic [DIV_W-1:0] div_q;

  // level of the selected tap; 0 when the rate is off
  function automatic logic tap_level(input logic [DIV_W-1:0] c,
                                     input logic [RATE_W-1:0] code);
    logic [RATE_W-1:0] idx;
    if (code == '0) return 1'b0;
    idx = code - 1'b1;
    return c[idx];
  endfunction

  // true when the bits below and at the tap are all ones, so the next
  // advance makes the tap fall
  function automatic logic tap_wrap(input logic [DIV_W-1:0] c,
                                    input logic [RATE_W-1:0] code);
    logic ok;
    ok = (code != '0);
    for (int i = 0; i < DIV_W; i++)
      if (i < int'(code)) ok = ok & c[i];
    return ok;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (osc_tick) div_q <= div_q + DIV_W'(1);
  end

  assign per_evt = osc_tick & tap_wrap(div_q, rate_code);
  assign sqw_out = sqw_en & tap_level(div_q, rate_code);

  AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> osc_tick);  // R2
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |-> (!per_evt && !sqw_out));  // R3
  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw_out);  // R4
endmodule

// File: rtl/pirq_flags.sv
module pirq_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en,
  input  logic            rd,
  output logic [NSRC-1:0] flag_q,
  output logic            any_req
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= (flag_q[g] & ~rd) | evt[g];
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flag_q[g]);  // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !rd) |=> flag_q[g]);  // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !evt[g]) |=> !flag_q[g]);  // R8
  end

  assign any_req = |(flag_q & en);
endmodule

// File: rtl/pirq_unit.sv
module pirq_unit
  import pirq_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [NSRC-1:0]   irq_en,
  input  logic              sqw_en,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_byte,
  output logic              irq,
  output logic              sqw_out
);
  logic            per_evt;
  logic [NSRC-1:0] src_evt;
  logic [NSRC-1:0] flag_q;
  logic            any_req;

  pirq_divider #(.RATE_W(RATE_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .rate_code (rate_code),
    .sqw_en    (sqw_en),
    .per_evt   (per_evt),
    .sqw_out   (sqw_out)
  );

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_UPD] = update_evt;
    src_evt[SRC_ALM] = alarm_evt;
    src_evt[SRC_PER] = per_evt;
  end

  pirq_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (src_evt),
    .en      (irq_en),
    .rd      (stat_rd),
    .flag_q  (flag_q),
    .any_req (any_req)
  );

  assign stat_byte = {any_req, flag_q, {STAT_FLAG_LSB{1'b0}}};
  assign irq       = any_req;

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !src_evt[SRC_UPD] && !src_evt[SRC_ALM] && !src_evt[SRC_PER]) |=> !irq);  // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != '0));  // R7
endmodule

// File: tb/pirq_unit_bench.sv
module pirq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic [2:0] irq_en = 3'b000;
  logic       sqw_en = 1'b0;
  logic       alarm_evt = 1'b0;
  logic       update_evt = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_byte;
  logic       irq;
  logic       sqw_out;

  int    n_run = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pirq_unit u_pirq_unit (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rate_code(rate_code),
    .irq_en(irq_en), .sqw_en(sqw_en), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .stat_rd(stat_rd), .stat_byte(stat_byte),
    .irq(irq), .sqw_out(sqw_out)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per read strobe
  always @(negedge clk) begin
    if (mon_on && stat_rd) begin
      if (exp_q.size() == 0) check("scoreboard", 1, 0);
      else check(tag_q.pop_front(), int'(stat_byte), int'(exp_q.pop_front()));
    end
  end

  task automatic read_expect(logic [7:0] exp, string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    stat_rd = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0;
  endtask

  task automatic pulse(bit alm, bit upd);
    @(posedge clk); #1;
    alarm_evt = alm; update_evt = upd;
    @(posedge clk); #1;
    alarm_evt = 1'b0; update_evt = 1'b0;
  endtask

  task automatic check_irq(int exp, string tag);
    @(negedge clk);
    check(tag, int'(irq), exp);
  endtask

  // holds the read strobe and the strobe high, measures periodic flag spacing
  // and square-wave high time
  task automatic measure(int code, bit pie);
    int gap;
    int hi;
    @(posedge clk); #1;
    rate_code = 4'(code); irq_en = {pie, 2'b00}; sqw_en = 1'b1;
    osc_tick = 1'b1; stat_rd = 1'b1;
    repeat (3) @(negedge clk);
    while (!stat_byte[6]) @(negedge clk);
    check("R7 summary bit", int'(stat_byte[7]), int'(pie));
    check("R7 irq pin", int'(irq), int'(pie));
    gap = 0;
    do begin @(negedge clk); gap++; end while (!stat_byte[6]);
    check($sformatf("R2 period code %0d", code), gap, 1 << code);
    while (!sqw_out) @(negedge clk);
    hi = 0;
    while (sqw_out) begin hi++; @(negedge clk); end
    check($sformatf("R4 high time code %0d", code), hi, 1 << (code - 1));
    @(posedge clk); #1;
    osc_tick = 1'b0; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int pf_seen;
    int sq_seen;
    repeat (3) @(negedge clk);
    check("R1 status", int'(stat_byte), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 sqw", int'(sqw_out), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    mon_on = 1'b1;

    // R6: alarm latches with its enable off
    pulse(1'b1, 1'b0);
    check_irq(0, "R6 irq stays low");
    read_expect(8'h20, "R5 R6 alarm flag");
    read_expect(8'h00, "R8 cleared by read");

    // R7: enabled alarm
    irq_en = 3'b010;
    pulse(1'b1, 1'b0);
    check_irq(1, "R7 alarm irq");
    read_expect(8'hA0, "R7 alarm summary");
    check_irq(0, "R8 irq after read");

    // update-ended enabled
    irq_en = 3'b001;
    pulse(1'b0, 1'b1);
    read_expect(8'h90, "R7 update summary");

    // enable raised after the flag is pending
    irq_en = 3'b000;
    pulse(1'b0, 1'b1);
    check_irq(0, "R6 disabled update");
    @(posedge clk); #1; irq_en = 3'b001;
    check_irq(1, "R7 late enable");
    read_expect(8'h90, "R7 late enable byte");

    // R9: event in the read cycle
    irq_en = 3'b000;
    @(posedge clk); #1;
    exp_q.push_back(8'h00); tag_q.push_back("R9 read before event");
    stat_rd = 1'b1; update_evt = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0; update_evt = 1'b0;
    read_expect(8'h10, "R9 event kept");

    // both sources at once
    irq_en = 3'b011;
    pulse(1'b1, 1'b1);
    read_expect(8'hB0, "R5 two flags");
    read_expect(8'h00, "R8 both cleared");
    mon_on = 1'b0;

    // periodic rates
    measure(1, 1'b1);
    measure(2, 1'b1);
    measure(3, 1'b0);
    measure(5, 1'b1);
    measure(9, 1'b1);
    measure(15, 1'b1);

    // R3: rate off
    @(posedge clk); #1;
    rate_code = 4'd0; irq_en = 3'b100; sqw_en = 1'b1;
    osc_tick = 1'b1; stat_rd = 1'b1;
    repeat (2) @(negedge clk);
    pf_seen = 0; sq_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (stat_byte[6]) pf_seen++;
      if (sqw_out) sq_seen++;
    end
    check("R3 no periodic flag", pf_seen, 0);
    check("R3 sqw low", sq_seen, 0);

    // R4: square wave disabled
    @(posedge clk); #1; rate_code = 4'd3; sqw_en = 1'b0;
    sq_seen = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (sqw_out) sq_seen++;
    end
    check("R4 sqw disabled", sq_seen, 0);
    @(posedge clk); #1; osc_tick = 1'b0; stat_rd = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule